// File: doc/BRIEF.md
# Instruction-Level Test Program Sequencer

This block drives a small ten-instruction accumulator datapath with a self-made test program and grades the answers that come back. Every test frame is four accepted instructions. The first loads the R register from the data bus. The second loads the accumulator A the same way. The third is the instruction under test. The fourth copies A to the datapath's output port. The sequencer predicts the output value for each frame and compares it with what the datapath shows.

A run has two phases. The scanning phase applies the add instruction to a computed table of operand pairs, which exercises the adder data function. The conformity phase keeps the operands fixed and places each of the ten instruction codes in turn into the test slot, which exercises the decoder. One start pulse runs both phases. At the end the block raises a done flag, a sticky fail flag, and the index of the first frame that went wrong.

Instructions leave the block on a valid/ready stream. Valid stays high for the whole run. A slot moves on only when valid and ready are both high. While ready is low, the opcode and data hold their values, and the datapath may stall for any number of cycles. The datapath's output register comes back on a plain input and is never back-pressured.

Top module: `test_prog_seq`

## Requirements
- R1: While reset is asserted, and after it is released, iss_valid, done and fail are 0 and fail_idx is 0.
- R2: A start pulse while the stream is idle begins a run, and iss_valid is 1 with opcode 5 in the next cycle. A start pulse while the stream is valid is ignored, and the run still issues exactly 72 instructions.
- R3: An instruction is accepted when iss_valid and iss_ready are both 1. While iss_valid is 1 and iss_ready is 0, iss_valid, iss_op and iss_data keep their values into the next cycle.
- R4: Every frame is four accepted instructions in this order:
  - opcode 5 (R takes the data bus), with data equal to the frame's R operand;
  - opcode 1 (A takes the data bus), with data equal to the frame's A operand;
  - the test opcode;
  - opcode 4 (the output port takes A), with data 0.
- R5: Frames 0 to 7 are scanning frames. Frame k uses A = (255 - 35k) mod 256 and R = (1 + 45k) mod 256. The test opcode is 7 (A takes A+R mod 256) and the test-slot data is 0.
- R6: Frames 8 to 17 are conformity frames with R = 0x0F and A = 0x35. The test opcode is frame-7 (1 to 10) and the test-slot data is 0xA6. The opcodes behave as follows:
  - 1 and 6: A takes the data bus;
  - 2: R takes A;
  - 3: the output port takes R;
  - 4: the output port takes A;
  - 5: R takes the data bus;
  - 7: A takes A+R;
  - 8: A takes A OR R;
  - 9: A takes A AND R;
  - 10: A takes NOT A.
- R7: The expected value of a frame is the A that results from the frame. It is compared with obs_data in the cycle after the output instruction is accepted.
- R8: On the first mismatch in a run, fail goes to 1 and fail_idx takes that frame's index. Later frames, matching or not, change neither.
- R9: After the check of frame 17, done is 1 and iss_valid is 0, and both hold until the next start. A start from idle clears done, fail and fail_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the stream is idle |
| iss_valid | output | 1 | Instruction slot holds a valid instruction |
| iss_ready | input | 1 | Datapath accepts the instruction slot |
| iss_op | output | 4 | Opcode of the instruction slot |
| iss_data | output | DW (8) | Value driven on the datapath data bus with the slot |
| obs_data | input | DW (8) | Datapath output port register |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_idx | output | IDX_W (5) | Frame index of the first mismatch |

## Verification
- **First instruction:** due in the cycle after the clock edge that samples start.
- **Output value:** the datapath updates its output register on the edge that accepts the output instruction. The sequencer compares that register on the following edge.
- **Status:** done, fail and fail_idx are visible one cycle after the output instruction is accepted.
- **Sampling:** the bench drives ready and samples every port on the falling clock edge. The slot it checks there is exactly the one the next rising edge accepts. It indexes its expected opcode and data by the datapath model's own count of accepted instructions, so stalls never shift a check.

// File: rtl/test_seq_pkg.sv
package test_seq_pkg;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_A_BUS   = 4'd1,
    OP_R_FROM_A = 4'd2,
    OP_OUT_R   = 4'd3,
    OP_OUT_A   = 4'd4,
    OP_R_BUS   = 4'd5,
    OP_A_BUS2  = 4'd6,
    OP_ADD     = 4'd7,
    OP_OR      = 4'd8,
    OP_AND     = 4'd9,
    OP_INV     = 4'd10
  } op_e;

  localparam int NUM_OPS   = 10;
  localparam int FRAME_LEN = 4;

  typedef enum logic [1:0] {
    SLOT_LOAD_R = 2'd0,
    SLOT_LOAD_A = 2'd1,
    SLOT_TEST   = 2'd2,
    SLOT_OBS    = 2'd3
  } slot_e;

endpackage

// File: rtl/seq_frame_gen.sv
module seq_frame_gen
  import test_seq_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SCAN_PAIRS  = 8,
  parameter int A_STEP      = 35,
  parameter int R_STEP      = 45,
  parameter logic [DW-1:0] CONF_A  = 8'h35,
  parameter logic [DW-1:0] CONF_R  = 8'h0F,
  parameter logic [DW-1:0] CONF_IN = 8'hA6,
  parameter int IDX_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             run_clr,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [3:0]       iss_op,
  output logic [DW-1:0]    iss_data,
  output logic             chk_stb,
  output logic [DW-1:0]    chk_exp,
  output logic [IDX_W-1:0] chk_idx,
  output logic             chk_last
);

  localparam int NUM_FRAMES = SCAN_PAIRS + NUM_OPS;
  localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(NUM_FRAMES - 1);

  logic             running;
  slot_e            slot;
  logic [IDX_W-1:0] frame;

  logic             is_scan;
  op_e              test_op;
  logic [DW-1:0]    a_val, r_val, bus_test, exp_a;
  logic             fire;

  function automatic logic [DW-1:0] scan_a(input logic [IDX_W-1:0] k);
    logic [DW-1:0] top;
    top = '1;
    return top - DW'(int'(k) * A_STEP);
  endfunction

  function automatic logic [DW-1:0] scan_r(input logic [IDX_W-1:0] k);
    return DW'(1 + int'(k) * R_STEP);
  endfunction

  function automatic logic [DW-1:0] model_a(input op_e op, input logic [DW-1:0] a,
                                            input logic [DW-1:0] r, input logic [DW-1:0] bus);
    case (op)
      OP_A_BUS, OP_A_BUS2: return bus;
      OP_ADD:              return a + r;
      OP_OR:               return a | r;
      OP_AND:              return a & r;
      OP_INV:              return ~a;
      default:             return a;
    endcase
  endfunction

  assign is_scan  = int'(frame) < SCAN_PAIRS;
  assign test_op  = is_scan ? OP_ADD : op_e'(4'(int'(frame) - SCAN_PAIRS + 1));
  assign a_val    = is_scan ? scan_a(frame) : CONF_A;
  assign r_val    = is_scan ? scan_r(frame) : CONF_R;
  assign bus_test = is_scan ? '0 : CONF_IN;
  assign exp_a    = model_a(test_op, a_val, r_val, bus_test);

  assign run_clr   = start && !running;
  assign iss_valid = running;
  assign fire      = running && iss_ready;

  always_comb begin
    case (slot)
      SLOT_LOAD_R: begin iss_op = OP_R_BUS;  iss_data = r_val;    end
      SLOT_LOAD_A: begin iss_op = OP_A_BUS;  iss_data = a_val;    end
      SLOT_TEST:   begin iss_op = test_op;   iss_data = bus_test; end
      default:     begin iss_op = OP_OUT_A;  iss_data = '0;       end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      slot     <= SLOT_LOAD_R;
      frame    <= '0;
      chk_stb  <= 1'b0;
      chk_exp  <= '0;
      chk_idx  <= '0;
      chk_last <= 1'b0;
    end else begin
      chk_stb <= fire && (slot == SLOT_OBS);
      if (fire && slot == SLOT_OBS) begin
        chk_exp  <= exp_a;
        chk_idx  <= frame;
        chk_last <= (frame == LAST_FRAME);
      end
      if (run_clr) begin
        running <= 1'b1;
        slot    <= SLOT_LOAD_R;
        frame   <= '0;
      end else if (fire) begin
        slot <= slot_e'(slot + 2'd1);
        if (slot == SLOT_OBS) begin
          frame <= frame + 1'b1;
          if (frame == LAST_FRAME) running <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/seq_result_cmp.sv
module seq_result_cmp #(
  parameter int DW    = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             chk_stb,
  input  logic [DW-1:0]    chk_exp,
  input  logic [IDX_W-1:0] chk_idx,
  input  logic             chk_last,
  input  logic [DW-1:0]    obs_data,
  output logic             done,
  output logic             fail,
  output logic [IDX_W-1:0] fail_idx
);

  logic mismatch;
  assign mismatch = chk_stb && (obs_data != chk_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      fail     <= 1'b0;
      fail_idx <= '0;
    end else if (clr) begin
      done     <= 1'b0;
      fail     <= 1'b0;
      fail_idx <= '0;
    end else if (chk_stb) begin
      if (mismatch && !fail) begin
        fail     <= 1'b1;
        fail_idx <= chk_idx;
      end
      if (chk_last) done <= 1'b1;
    end
  end

endmodule

// File: rtl/test_prog_seq.sv
module test_prog_seq
  import test_seq_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SCAN_PAIRS = 8,
  parameter int IDX_W      = $clog2(SCAN_PAIRS + NUM_OPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [3:0]       iss_op,
  output logic [DW-1:0]    iss_data,
  input  logic [DW-1:0]    obs_data,
  output logic             done,
  output logic             fail,
  output logic [IDX_W-1:0] fail_idx
);

  logic             run_clr;
  logic             chk_stb;
  logic [DW-1:0]    chk_exp;
  logic [IDX_W-1:0] chk_idx;
  logic             chk_last;

  seq_frame_gen #(
    .DW(DW), .SCAN_PAIRS(SCAN_PAIRS), .IDX_W(IDX_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .run_clr(run_clr),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op), .iss_data(iss_data),
    .chk_stb(chk_stb), .chk_exp(chk_exp), .chk_idx(chk_idx), .chk_last(chk_last)
  );

  seq_result_cmp #(
    .DW(DW), .IDX_W(IDX_W)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(run_clr),
    .chk_stb(chk_stb), .chk_exp(chk_exp), .chk_idx(chk_idx), .chk_last(chk_last),
    .obs_data(obs_data), .done(done), .fail(fail), .fail_idx(fail_idx)
  );

endmodule

// File: rtl/test_prog_seq_chk.sv
module test_prog_seq_chk #(
  parameter int DW    = 8,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [3:0]       iss_op,
  input logic [DW-1:0]    iss_data,
  input logic             done,
  input logic             fail,
  input logic [IDX_W-1:0] fail_idx
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!iss_valid && !done && !fail && fail_idx == '0));

  // R2
  start_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !iss_valid) |=> (iss_valid && iss_op == 4'd5));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_op) && $stable(iss_data)));

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !iss_valid)) |=> (fail && $stable(fail_idx)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !iss_valid);

endmodule

bind test_prog_seq test_prog_seq_chk #(.DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_op(iss_op), .iss_data(iss_data), .done(done), .fail(fail), .fail_idx(fail_idx)
);

// File: tb/tb_test_prog_seq.sv
module tb_test_prog_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       iss_valid;
  logic       iss_ready = 1'b1;
  logic [3:0] iss_op;
  logic [7:0] iss_data;
  logic [7:0] obs_data;
  logic       done, fail;
  logic [4:0] fail_idx;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  test_prog_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_data(iss_data), .obs_data(obs_data),
    .done(done), .fail(fail), .fail_idx(fail_idx)
  );

  // datapath model
  logic [7:0]  ra = '0, rr = '0, rout = '0;
  int          dp_hs = 0;
  logic        dp_clr = 1'b0;
  logic [31:0] fault_mask = '0;
  bit          stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  assign obs_data = rout;

  always @(posedge clk) begin
    if (dp_clr) dp_hs <= 0;
    else if (iss_valid && iss_ready) begin
      case (iss_op)
        4'd1, 4'd6: ra <= iss_data;
        4'd2:  rr <= ra;
        4'd3:  rout <= rr;
        4'd4:  rout <= ra ^ (fault_mask[dp_hs/4] ? 8'h01 : 8'h00);
        4'd5:  rr <= iss_data;
        4'd7:  ra <= ra + rr;
        4'd8:  ra <= ra | rr;
        4'd9:  ra <= ra & rr;
        4'd10: ra <= ~ra;
        default: ;
      endcase
      dp_hs <= dp_hs + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: drives ready, then checks the slot the next edge accepts
  bit         prev_stall = 1'b0;
  logic [3:0] prev_op = '0;
  logic [7:0] prev_data = '0;

  always @(negedge clk) begin
    int fr, st, a, r, top, tin, eop, edat;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    iss_ready = stall_mode ? lfsr[0] : 1'b1;
    if (rst_n) begin
      if (prev_stall) begin
        check(iss_valid && iss_op == prev_op && iss_data == prev_data,
              "R3", "stalled slot changed", {iss_op, iss_data}, {prev_op, prev_data});
      end
      if (iss_valid && iss_ready) begin
        fr = dp_hs / 4;
        st = dp_hs % 4;
        if (fr < 8) begin
          a = (255 - 35 * fr) % 256; r = (1 + 45 * fr) % 256; top = 7; tin = 0;  // R5
        end else begin
          a = 'h35; r = 'h0F; top = fr - 7; tin = 'hA6;                          // R6
        end
        case (st)
          0: begin eop = 5;   edat = r;   end
          1: begin eop = 1;   edat = a;   end
          2: begin eop = top; edat = tin; end
          default: begin eop = 4; edat = 0; end
        endcase
        check(int'(iss_op) == eop, "R4", "slot opcode", int'(iss_op), eop);
        check(int'(iss_data) == edat, fr < 8 ? "R5" : "R6", "slot data", int'(iss_data), edat);
      end
      prev_stall = iss_valid && !iss_ready;
      prev_op    = iss_op;
      prev_data  = iss_data;
    end
  end

  task automatic run(input bit st, input logic [31:0] mask, input bit efail,
                     input int eidx, input bit midstart);
    int n;
    @(negedge clk);
    stall_mode = st;
    fault_mask = mask;
    dp_clr = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dp_clr = 1'b0;
    check(iss_valid && iss_op == 4'd5, "R2", "first slot after start", {iss_valid, iss_op}, 'h15);
    check(!done && !fail && fail_idx == 0, "R9", "status cleared by start",
          {done, fail, fail_idx}, 0);
    n = 0;
    while (!done && n < 3000) begin
      if (midstart && n == 20) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(done == 1'b1, "R9", "done after last frame", done, 1);
    check(!iss_valid, "R9", "stream idle at done", iss_valid, 0);
    check(dp_hs == 72, "R2", "accepted instruction count", dp_hs, 72);
    check(fail == efail, "R7", "fail flag", fail, efail);
    check(int'(fail_idx) == eidx, "R8", "first mismatch index", fail_idx, eidx);
    repeat (3) @(negedge clk);
    check(done && !iss_valid && fail == efail && int'(fail_idx) == eidx, "R9",
          "status held while idle", {done, iss_valid, fail, fail_idx}, {1'b1, 1'b0, efail, 5'(eidx)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!iss_valid && !done && !fail && fail_idx == 0, "R1", "state in reset",
          {iss_valid, done, fail, fail_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!iss_valid && !done && !fail && fail_idx == 0, "R1", "state after reset",
          {iss_valid, done, fail, fail_idx}, 0);
    run(1'b0, 32'h0,                       1'b0, 0,  1'b0); // R5 R6 clean, no stalls
    run(1'b1, 32'h0,                       1'b0, 0,  1'b1); // R2 start while busy, R3 stalls
    run(1'b1, 32'h1 << 3,                  1'b1, 3,  1'b0); // R8 scan frame
    run(1'b0, 32'h1 << 17,                 1'b1, 17, 1'b0); // R8 last frame
    run(1'b1, (32'h1 << 9) | (32'h1 << 14), 1'b1, 9, 1'b0); // R8 first of two
    run(1'b0, 32'h1 << 12,                 1'b1, 12, 1'b0); // R7 conformity frame
    run(1'b1, 32'h0,                       1'b0, 0,  1'b0); // R9 clears old fail
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule